// File: doc/BRIEF.md
# Battery Charge Path Controller

This block decides, every clock, whether the external pass transistor between a wall adapter and a lithium-ion battery is conducting. It works on digitized millivolt codes for the adapter input, the battery and the voltage across the current-sense resistor. It also takes a flag from the lockout logic and two processor pins: one hands over control and one sets the gate.

When the processor leaves control to the block, charging is automatic. The block first detects an adapter using a hysteresis window. It then trickle-charges while the battery has not passed lockout, and switches to full-current charging once it has. At the final voltage it moves to a constant-voltage phase. Current limiting is modelled as on/off control: the gate is opened for a cycle whenever the sense code goes over the selected limit. A latched end-of-charge flag reports the taper point.

When the processor takes control, as it does for nickel chemistries, the gate simply follows the processor's gate pin. Driving both processor pins high ends the charge.

Top module: `chg_ctrl_top`

## Requirements
- R1: `adp_present` rises only when `adp_mv - bat_mv` is 90 or more, with the codes read as millivolts. A gap of 89 leaves it low.
- R2: Once high, `adp_present` stays high while the gap is above 45. It falls when the gap is 45 or less, including when the adapter is below the battery.
- R3: After reset, `adp_present`, `charge_done`, `ilim_full` and `cv_mode` are 0 and `gate_off` is 1.
- R4: While no adapter is detected, `gate_off` is 1 and `ilim_full` and `cv_mode` are 0.
- R5: In automatic mode (`host_ctl`=0) with an adapter present and `lockout_ok`=0, the block trickle-charges. `ilim_full` is 0, `gate_off` is 0 while `sense_mv` is 20 or less, and `gate_off` is 1 while `sense_mv` is 21 or more.
- R6: In automatic mode with `lockout_ok`=1 and the battery below 4200, the block charges at constant current. `ilim_full` is 1, and `gate_off` is 1 only while `sense_mv` is above 160.
- R7: In automatic mode with `lockout_ok`=1, `bat_mv` of 4200 or more sets `cv_mode` and `ilim_full`, with `gate_off` 0. `cv_mode` then stays set while automatic mode, lockout and the adapter persist, even if the battery drops below 4200.
- R8: `charge_done` sets during full-current or constant-voltage charging when `bat_mv` > 4000 and `sense_mv` <= 14. A battery of exactly 4000 does not set it. Once set, it stays set when the sense voltage rises again.
- R9: With `host_ctl`=1 and an adapter present, `gate_off` equals `host_gate` one clock later, and `ilim_full` and `cv_mode` are 0.
- R10: `host_ctl`=1 together with `host_gate`=1 ends the charge: `gate_off` is 1 and `charge_done` is cleared on the next clock.
- R11: Removing the adapter clears `charge_done`.
- R12: A single-cycle excursion of `sense_mv` above the limit in a current-limited phase drives `gate_off` high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adp_mv | input | 13 | Adapter input voltage code, mV |
| bat_mv | input | 13 | Battery sense voltage code, mV |
| sense_mv | input | 9 | Voltage across sense resistor, mV |
| lockout_ok | input | 1 | Battery is above the lockout threshold |
| host_ctl | input | 1 | Processor takes gate control |
| host_gate | input | 1 | Processor gate level (1 = off) |
| adp_present | output | 1 | Adapter detected |
| charge_done | output | 1 | Latched end-of-charge |
| gate_off | output | 1 | Pass-device gate drive, 1 = off |
| ilim_full | output | 1 | Full current limit selected (0 = trickle) |
| cv_mode | output | 1 | Constant-voltage phase |

## Verification
The main function is driven through a walk of adapter and battery gaps and sense levels. Adapter gaps sit one code either side of both hysteresis edges, which separates the rising threshold from the falling one. Sense levels sit one code either side of the trickle limit, the full limit and the end-of-charge level, which shows which limit is actually selected in each phase. Battery levels at 4000/4001 and 4200/4100 separate the end-of-charge qualification from the sticky constant-voltage entry. Directed sequences then check the exact one-clock width of a limit pulse and the one-clock latency of the processor passthrough.

// File: rtl/chg_pkg.sv
// Shared types for the charge path controller.
package chg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TRICKLE = 3'd1,
        ST_CC      = 3'd2,
        ST_CV      = 3'd3,
        ST_HOST    = 3'd4
    } chg_state_e;
endpackage

// File: rtl/chg_adapter_detect.sv
// Adapter presence detector with a hysteresis window.
// Assumes both codes are unsigned mV values of the same scale; the adapter
// may be below the battery, so the gap is computed signed.
module chg_adapter_detect #(
    parameter int V_W    = 13,
    parameter int ON_MV  = 90,
    parameter int OFF_MV = 45
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [V_W-1:0] adp_mv,
    input  logic [V_W-1:0] bat_mv,
    output logic           present
);
    localparam logic signed [V_W:0] ON_S  = (V_W+1)'(ON_MV);
    localparam logic signed [V_W:0] OFF_S = (V_W+1)'(OFF_MV);

    logic signed [V_W:0] gap;

    // Signed headroom of the adapter over the battery.
    always_comb gap = $signed({1'b0, adp_mv}) - $signed({1'b0, bat_mv});

    // Presence flag: rise at the upper edge, fall at the lower edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          present <= 1'b0;
        else if (!present)   present <= (gap >= ON_S);
        else                 present <= (gap > OFF_S);
    end
endmodule

// File: rtl/chg_phase_fsm.sv
// Charge phase sequencer and end-of-charge latch.
// Assumes the presence flag is already registered; the phase and latch
// react one clock after their inputs.
module chg_phase_fsm
    import chg_pkg::*;
#(
    parameter int V_W      = 13,
    parameter int S_W      = 9,
    parameter int CV_MV    = 4200,
    parameter int EOC_B_MV = 4000,
    parameter int EOC_S_MV = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           present,
    input  logic           lockout_ok,
    input  logic           host_ctl,
    input  logic           host_gate,
    input  logic [V_W-1:0] bat_mv,
    input  logic [S_W-1:0] sense_mv,
    output chg_state_e     state,
    output logic           done
);
    localparam logic [V_W-1:0] CV_LVL  = V_W'(CV_MV);
    localparam logic [V_W-1:0] EOC_BAT = V_W'(EOC_B_MV);
    localparam logic [S_W-1:0] EOC_SNS = S_W'(EOC_S_MV);

    chg_state_e nxt;
    logic       terminate;
    logic       taper;

    // Processor termination request and taper detection.
    always_comb begin
        terminate = host_ctl && host_gate;
        taper     = ((state == ST_CC) || (state == ST_CV)) &&
                    (bat_mv > EOC_BAT) && (sense_mv <= EOC_SNS);
    end

    // Next phase from adapter, ownership, lockout and battery level.
    always_comb begin
        if (!present)                         nxt = ST_IDLE;
        else if (host_ctl)                    nxt = ST_HOST;
        else if (!lockout_ok)                 nxt = ST_TRICKLE;
        else if ((state == ST_CV) || (bat_mv >= CV_LVL)) nxt = ST_CV;
        else                                  nxt = ST_CC;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // End-of-charge latch: clear on removal or termination, else set on taper.
    always_ff @(posedge clk) begin
        if (!rst_n)                     done <= 1'b0;
        else if (!present || terminate) done <= 1'b0;
        else if (taper)                 done <= 1'b1;
    end
endmodule

// File: rtl/chg_gate_drive.sv
// Pass-device gate driver with on/off current limiting.
// Assumes the phase comes from a register; the gate output is registered,
// so each limit excursion opens the gate for one clock per sample.
module chg_gate_drive
    import chg_pkg::*;
#(
    parameter int S_W       = 9,
    parameter int TRICKLE_MV = 20,
    parameter int FULL_MV   = 160
) (
    input  logic           clk,
    input  logic           rst_n,
    input  chg_state_e     state,
    input  logic           present,
    input  logic           host_ctl,
    input  logic           host_gate,
    input  logic [S_W-1:0] sense_mv,
    output logic           gate_off
);
    localparam int N_LIM = 2;
    localparam logic [S_W-1:0] LIM_TAB [N_LIM] = '{S_W'(TRICKLE_MV), S_W'(FULL_MV)};

    logic [N_LIM-1:0] over;
    logic             lim_sel;
    logic             gate_nxt;

    // One comparator per limit level.
    for (genvar i = 0; i < N_LIM; i++) begin : g_lim
        assign over[i] = (sense_mv > LIM_TAB[i]);
    end

    // Limit select: full current outside the trickle phase.
    always_comb lim_sel = (state != ST_TRICKLE);

    // Next gate level by ownership and phase.
    always_comb begin
        if (!present)      gate_nxt = 1'b1;
        else if (host_ctl) gate_nxt = host_gate;
        else begin
            unique case (state)
                ST_TRICKLE, ST_CC: gate_nxt = over[lim_sel];
                ST_CV:             gate_nxt = 1'b0;
                default:           gate_nxt = 1'b1;
            endcase
        end
    end

    // Gate register, off at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_off <= 1'b1;
        else        gate_off <= gate_nxt;
    end
endmodule

// File: rtl/chg_ctrl_top.sv
// Charge path controller top: adapter detection, phase sequencing and
// gate drive. Assumes all analog quantities arrive as synchronous mV codes.
module chg_ctrl_top
    import chg_pkg::*;
#(
    parameter int V_W        = 13,
    parameter int S_W        = 9,
    parameter int DET_ON_MV  = 90,
    parameter int DET_OFF_MV = 45,
    parameter int TRICKLE_MV = 20,
    parameter int FULL_MV    = 160,
    parameter int CV_MV      = 4200,
    parameter int EOC_B_MV   = 4000,
    parameter int EOC_S_MV   = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [V_W-1:0] adp_mv,
    input  logic [V_W-1:0] bat_mv,
    input  logic [S_W-1:0] sense_mv,
    input  logic           lockout_ok,
    input  logic           host_ctl,
    input  logic           host_gate,
    output logic           adp_present,
    output logic           charge_done,
    output logic           gate_off,
    output logic           ilim_full,
    output logic           cv_mode
);
    chg_state_e phase;

    chg_adapter_detect #(.V_W(V_W), .ON_MV(DET_ON_MV), .OFF_MV(DET_OFF_MV)) u_det (
        .clk(clk), .rst_n(rst_n), .adp_mv(adp_mv), .bat_mv(bat_mv),
        .present(adp_present)
    );

    chg_phase_fsm #(.V_W(V_W), .S_W(S_W), .CV_MV(CV_MV),
                    .EOC_B_MV(EOC_B_MV), .EOC_S_MV(EOC_S_MV)) u_fsm (
        .clk(clk), .rst_n(rst_n), .present(adp_present),
        .lockout_ok(lockout_ok), .host_ctl(host_ctl), .host_gate(host_gate),
        .bat_mv(bat_mv), .sense_mv(sense_mv), .state(phase), .done(charge_done)
    );

    chg_gate_drive #(.S_W(S_W), .TRICKLE_MV(TRICKLE_MV), .FULL_MV(FULL_MV)) u_gate (
        .clk(clk), .rst_n(rst_n), .state(phase), .present(adp_present),
        .host_ctl(host_ctl), .host_gate(host_gate), .sense_mv(sense_mv),
        .gate_off(gate_off)
    );

    // Phase decode for the limit select and constant-voltage flag.
    always_comb begin
        ilim_full = (phase == ST_CC) || (phase == ST_CV);
        cv_mode   = (phase == ST_CV);
    end
endmodule

// File: rtl/chg_ctrl_chk.sv
// Property checker for the charge path controller, bound to the top.
module chg_ctrl_chk #(
    parameter int V_W = 13,
    parameter int S_W = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic [V_W-1:0] adp_mv,
    input logic [V_W-1:0] bat_mv,
    input logic [S_W-1:0] sense_mv,
    input logic           lockout_ok,
    input logic           host_ctl,
    input logic           host_gate,
    input logic           adp_present,
    input logic           charge_done,
    input logic           gate_off,
    input logic           ilim_full,
    input logic           cv_mode
);
    assert_gate_off_no_adp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adp_present |=> gate_off);

    assert_host_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_present && host_ctl) |=> (gate_off == $past(host_gate)));

    assert_term_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_present && host_ctl && host_gate) |=> !charge_done);

    assert_removal_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !adp_present |=> !charge_done);

    assert_cv_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_mode && adp_present && !host_ctl && lockout_ok) |=> cv_mode);

    assert_cv_full_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cv_mode |-> ilim_full);

    assert_done_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_done && adp_present && !(host_ctl && host_gate)) |=> charge_done);
endmodule

bind chg_ctrl_top chg_ctrl_chk #(.V_W(V_W), .S_W(S_W)) u_chk (.*);

// File: tb/sim_chg_ctrl_top.sv
module sim_chg_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] adp_mv = '0, bat_mv = '0;
    logic [8:0]  sense_mv = '0;
    logic        lockout_ok = 1'b0, host_ctl = 1'b0, host_gate = 1'b0;
    logic        adp_present, charge_done, gate_off, ilim_full, cv_mode;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    chg_ctrl_top u0 (.*);

    // Vector: inputs, then expected {present, done, gate_off, ilim_full, cv_mode}.
    typedef struct packed {
        logic [12:0] adp;
        logic [12:0] bat;
        logic [8:0]  sns;
        logic        lck;
        logic        hc;
        logic        hg;
        logic [4:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{13'd0,    13'd3700, 9'd0,   1'b1, 1'b0, 1'b0, 5'b00100, 8'd4},  // R4 no adapter
        '{13'd3789, 13'd3700, 9'd0,   1'b1, 1'b0, 1'b0, 5'b00100, 8'd1},  // R1 gap 89
        '{13'd3790, 13'd3700, 9'd0,   1'b1, 1'b0, 1'b0, 5'b10010, 8'd1},  // R1 gap 90
        '{13'd3746, 13'd3700, 9'd0,   1'b1, 1'b0, 1'b0, 5'b10010, 8'd2},  // R2 gap 46 holds
        '{13'd3745, 13'd3700, 9'd0,   1'b1, 1'b0, 1'b0, 5'b00100, 8'd2},  // R2 gap 45 drops
        '{13'd5000, 13'd3700, 9'd20,  1'b0, 1'b0, 1'b0, 5'b10000, 8'd5},  // R5 trickle at limit
        '{13'd5000, 13'd3700, 9'd21,  1'b0, 1'b0, 1'b0, 5'b10100, 8'd5},  // R5 trickle over
        '{13'd5000, 13'd3700, 9'd160, 1'b1, 1'b0, 1'b0, 5'b10010, 8'd6},  // R6 full at limit
        '{13'd5000, 13'd3700, 9'd161, 1'b1, 1'b0, 1'b0, 5'b10110, 8'd6},  // R6 full over
        '{13'd5000, 13'd4200, 9'd100, 1'b1, 1'b0, 1'b0, 5'b10011, 8'd7},  // R7 enter CV
        '{13'd5000, 13'd4100, 9'd100, 1'b1, 1'b0, 1'b0, 5'b10011, 8'd7},  // R7 CV sticky
        '{13'd5000, 13'd4100, 9'd14,  1'b1, 1'b0, 1'b0, 5'b11011, 8'd8},  // R8 taper sets
        '{13'd5000, 13'd4100, 9'd100, 1'b1, 1'b0, 1'b0, 5'b11011, 8'd8},  // R8 latched
        '{13'd5000, 13'd4100, 9'd100, 1'b1, 1'b1, 1'b0, 5'b11000, 8'd9},  // R9 host, gate on
        '{13'd5000, 13'd4100, 9'd100, 1'b1, 1'b1, 1'b1, 5'b10100, 8'd10}, // R10 terminate
        '{13'd5000, 13'd4100, 9'd14,  1'b1, 1'b0, 1'b0, 5'b11010, 8'd8},  // R8 CC taper
        '{13'd0,    13'd4100, 9'd14,  1'b1, 1'b0, 1'b0, 5'b00100, 8'd11}, // R11 removal
        '{13'd5000, 13'd4000, 9'd14,  1'b1, 1'b0, 1'b0, 5'b10010, 8'd8},  // R8 bat 4000 no set
        '{13'd5000, 13'd4001, 9'd14,  1'b1, 1'b0, 1'b0, 5'b11010, 8'd8}   // R8 bat 4001 sets
    };

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {adp_present, charge_done, gate_off, ilim_full, cv_mode};
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state (inputs show no adapter)
        chk("R3 reset", outs(), 5'b00100);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            adp_mv = VECS[i].adp; bat_mv = VECS[i].bat; sense_mv = VECS[i].sns;
            lockout_ok = VECS[i].lck; host_ctl = VECS[i].hc; host_gate = VECS[i].hg;
            repeat (6) @(negedge clk);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), outs(), VECS[i].exp);
        end

        // R12 single-cycle limit pulse during constant current
        @(negedge clk);
        bat_mv = 13'd3700; sense_mv = 9'd50;
        repeat (6) @(negedge clk);
        chk("R12 before pulse", {4'b0, gate_off}, 5'b0);
        sense_mv = 9'd200;
        @(negedge clk);
        sense_mv = 9'd50;
        chk("R12 pulse high", {4'b0, gate_off}, 5'b1);
        @(negedge clk);
        chk("R12 pulse ends", {4'b0, gate_off}, 5'b0);

        // R9 passthrough latency of one clock
        host_ctl = 1'b1; host_gate = 1'b0;
        repeat (3) @(negedge clk);
        host_gate = 1'b1;
        chk("R9 before edge", {4'b0, gate_off}, 5'b0);
        @(negedge clk);
        chk("R9 after edge", {4'b0, gate_off}, 5'b1);
        host_gate = 1'b0;
        @(negedge clk);
        chk("R9 back on", {4'b0, gate_off}, 5'b0);

        // R3 reset mid-charge returns to the reset state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R3 reset during charge", outs(), 5'b00100);
        rst_n = 1'b1;

        finish_run();
    end
endmodule